// File: doc/BRIEF.md
# Byte-Lane FIFO with Unequal Port Widths

This block is a single-clock first-in first-out buffer whose storage is an array of bytes. The producer side takes a word of several bytes per transfer, the consumer side takes a word of a different number of bytes per transfer. On every accepted push all bytes of the input word land in storage in the same clock, and the write pointer moves on by the input byte count. On every accepted pop a word of consecutive bytes is gathered, and the read pointer moves on by the output byte count. Bytes keep their little-endian order, so the lowest byte of a word always sits at the lowest address.

The producer side is a valid/ready stream. A push is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while fewer free bytes remain than one input word holds. A producer may hold `in_valid` high while `in_ready` is low; that word is not taken and it must be offered again. The consumer side is a request/response pair. `out_avail` is high while at least one output word of bytes is stored. A pop is accepted on an edge where `out_req` and `out_avail` are both high, and the word appears one clock later with a one-cycle `out_valid` strobe. There is no back-pressure on the response, so the consumer must take the word in the cycle of the strobe.

Byte size, both port widths and the address width are parameters. Elaboration stops if either port width is not a whole number of bytes, or if the depth is not a multiple of both byte strides.

Top module: `bytelane_fifo`

## Requirements
- R1: A synchronous active-high `rst` empties the buffer. On the first cycle after reset `in_ready` is 1, `out_avail` is 0 and `out_valid` is 0.
- R2: An accepted push stores input byte i (bits BYTE_W*(i+1)-1 down to BYTE_W*i of `in_data`) at address write pointer + i, for all IN_W/BYTE_W bytes in one clock. The write pointer then advances by IN_W/BYTE_W.
- R3: An accepted pop returns in output byte j (bits BYTE_W*(j+1)-1 down to BYTE_W*j of `out_data`) the byte at address read pointer + j. The read pointer then advances by OUT_W/BYTE_W. The bytes read back form the same byte stream that was pushed, in order.
- R4: `out_valid` is high in exactly the cycle after each accepted pop, with `out_data` valid in that cycle.
- R5: `in_ready` is low exactly when fewer than IN_W/BYTE_W bytes are free. `out_avail` is low exactly when fewer than OUT_W/BYTE_W bytes are stored.
- R6: A push offered while `in_ready` is low is ignored. It changes neither the stored bytes nor the occupancy.
- R7: A pop requested while `out_avail` is low is ignored. No `out_valid` follows, and neither the read pointer nor the occupancy changes.
- R8: When a push and a pop are accepted on the same edge, the occupancy changes by IN_W/BYTE_W minus OUT_W/BYTE_W.
- R9: Both pointers wrap modulo the depth of 2^ADDR_W bytes. A word that straddles the top address continues at address 0.
- R10: `out_data` holds its value until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Room for one more input word |
| in_data | input | IN_W | Input word, least significant byte first in address order |
| out_req | input | 1 | Consumer requests a word |
| out_avail | output | 1 | At least one output word of bytes is stored |
| out_valid | output | 1 | One-cycle strobe: `out_data` carries a popped word |
| out_data | output | OUT_W | Output word, registered |

## Verification
The assertions take for granted only that inputs are known after reset. They do not assume that the producer respects `in_ready` or that the consumer respects `out_avail`. The properties on ignored transfers are therefore written for the case in which the stimulus breaks those rules. The stimulus draws `in_valid` and `out_req` from biased random weights that change by phase, so long stretches of pushes into a full buffer and pops from an empty one occur alongside the legal traffic. One reset is also applied in the middle of the run, while data is stored.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

  // Number of whole bytes in a bus of the given width.
  function automatic int lanes_of(input int bus_w, input int byte_w);
    return bus_w / byte_w;
  endfunction

endpackage

// File: rtl/bytelane_ctrl.sv
// Pointer and occupancy bookkeeping, all in bytes.
module bytelane_ctrl #(
  parameter int ADDR_W = 5,
  parameter int IN_B   = 4,
  parameter int OUT_B  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              room,
  output logic              have,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W:0]   occ
);
  localparam int              DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V  = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0] IN_STEP  = (ADDR_W+1)'(IN_B);
  localparam logic [ADDR_W:0] OUT_STEP = (ADDR_W+1)'(OUT_B);

  logic [ADDR_W:0] free_b;

  assign free_b  = DEPTH_V - occ;
  assign room    = free_b >= IN_STEP;
  assign have    = occ >= OUT_STEP;
  assign push_ok = push_req & room;
  assign pop_ok  = pop_req & have;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + IN_STEP[ADDR_W-1:0];
      if (pop_ok)  rd_ptr <= rd_ptr + OUT_STEP[ADDR_W-1:0];
      case ({push_ok, pop_ok})
        2'b10:   occ <= occ + IN_STEP;
        2'b01:   occ <= occ - OUT_STEP;
        2'b11:   occ <= occ + IN_STEP - OUT_STEP;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/bytelane_store.sv
// Byte array with a multi-byte write lane set and a registered multi-byte read.
module bytelane_store #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 5,
  parameter int IN_B   = 4,
  parameter int OUT_B  = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wa,
  input  logic [IN_B*BYTE_W-1:0]  wdata,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       ra,
  output logic [OUT_B*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] w_addr [IN_B];
  logic [ADDR_W-1:0] r_addr [OUT_B];

  // Per-lane addresses; the adder width gives the wrap at the top of storage.
  for (genvar wl = 0; wl < IN_B; wl++) begin : g_wlane
    assign w_addr[wl] = wa + ADDR_W'(wl);
  end
  for (genvar rl = 0; rl < OUT_B; rl++) begin : g_rlane
    assign r_addr[rl] = ra + ADDR_W'(rl);
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < IN_B; i++) begin
        mem[w_addr[i]] <= wdata[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      for (int j = 0; j < OUT_B; j++) begin
        rdata[j*BYTE_W +: BYTE_W] <= mem[r_addr[j]];
      end
    end
  end
endmodule

// File: rtl/bytelane_fifo.sv
module bytelane_fifo
  import bytelane_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IN_W   = 32,
  parameter int OUT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             out_req,
  output logic             out_avail,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int IN_B  = lanes_of(IN_W, BYTE_W);
  localparam int OUT_B = lanes_of(OUT_W, BYTE_W);
  localparam int DEPTH = 1 << ADDR_W;

  if (IN_W % BYTE_W != 0) begin : g_bad_in
    $error("input width is not a whole number of bytes");
  end
  if (OUT_W % BYTE_W != 0) begin : g_bad_out
    $error("output width is not a whole number of bytes");
  end
  if ((DEPTH % IN_B != 0) || (DEPTH % OUT_B != 0)) begin : g_bad_depth
    $error("depth is not a multiple of both byte strides");
  end

  logic              push_ok, pop_ok;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W:0]   occ;

  bytelane_ctrl #(
    .ADDR_W(ADDR_W), .IN_B(IN_B), .OUT_B(OUT_B)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(in_valid), .pop_req(out_req),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .room(in_ready), .have(out_avail),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ)
  );

  bytelane_store #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .IN_B(IN_B), .OUT_B(OUT_B)
  ) u_store (
    .clk(clk),
    .we(push_ok), .wa(wr_ptr), .wdata(in_data),
    .re(pop_ok), .ra(rd_ptr), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= pop_ok;
  end
endmodule

// File: rtl/bytelane_fifo_chk.sv
module bytelane_fifo_chk #(
  parameter int ADDR_W = 5,
  parameter int IN_B   = 4,
  parameter int OUT_B  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_req,
  input logic            out_avail,
  input logic            out_valid,
  input logic [ADDR_W:0] occ
);
  localparam logic [ADDR_W:0] DEPTH_V  = (ADDR_W+1)'(1 << ADDR_W);
  localparam logic [ADDR_W:0] IN_STEP  = (ADDR_W+1)'(IN_B);
  localparam logic [ADDR_W:0] OUT_STEP = (ADDR_W+1)'(OUT_B);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= DEPTH_V);

  // R4
  pop_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (out_req && out_avail) |=> out_valid);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_req && !out_avail) |=> !out_valid);

  // R6
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !(out_req && out_avail)) |=> $stable(occ));

  // R8
  both_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_req && out_avail)
      |=> occ == $past(occ) + IN_STEP - OUT_STEP);
endmodule

bind bytelane_fifo bytelane_fifo_chk #(
  .ADDR_W(ADDR_W), .IN_B(IN_B), .OUT_B(OUT_B)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_req(out_req), .out_avail(out_avail), .out_valid(out_valid), .occ(occ)
);

// File: tb/tb_bytelane_fifo.sv
`timescale 1ns/1ps
module tb_bytelane_fifo;
  localparam int BYTE_W = 8;
  localparam int IN_W   = 32;
  localparam int OUT_W  = 16;
  localparam int ADDR_W = 5;
  localparam int IN_B   = IN_W / BYTE_W;
  localparam int OUT_B  = OUT_W / BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_data = '0;
  logic             out_req = 1'b0;
  logic             out_avail;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  bytelane_fifo #(
    .BYTE_W(BYTE_W), .IN_W(IN_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_req(out_req), .out_avail(out_avail),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model: the byte stream held in order.
  logic [BYTE_W-1:0] q [$];
  logic [OUT_W-1:0]  exp_data = '0;
  bit exp_valid = 1'b0;
  bit have_word = 1'b0;
  bit last_wr_rej = 1'b0, last_rd_rej = 1'b0, last_both = 1'b0;
  int popped = 0;

  function automatic bit exp_ready(input int n);
    return (DEPTH - n) >= IN_B;
  endfunction

  function automatic bit exp_avail(input int n);
    return n >= OUT_B;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete();
    exp_valid = 1'b0; have_word = 1'b0;
    last_wr_rej = 1'b0; last_rd_rej = 1'b0; last_both = 1'b0;
    @(negedge clk);
    // R1: state on the first cycle after reset
    chk(in_ready == 1'b1,  "R1 in_ready",  in_ready,  1);
    chk(out_avail == 1'b0, "R1 out_avail", out_avail, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic check_outputs();
    string tr, ta, tv, td;
    tr = last_wr_rej ? "R6 in_ready after rejected push" :
         last_both   ? "R8 in_ready after joint transfer" : "R5 in_ready";
    ta = last_both   ? "R8 out_avail after joint transfer" : "R5 out_avail";
    tv = last_rd_rej ? "R7 out_valid after rejected pop" : "R4 out_valid";
    td = (popped > DEPTH) ? "R9 out_data after wrap" : "R3 out_data";
    chk(in_ready == exp_ready(q.size()), tr, in_ready, exp_ready(q.size()));
    chk(out_avail == exp_avail(q.size()), ta, out_avail, exp_avail(q.size()));
    chk(out_valid == exp_valid, tv, out_valid, exp_valid);
    if (exp_valid) chk(out_data == exp_data, td, out_data, exp_data);
    else if (have_word) chk(out_data == exp_data, "R10 out_data hold", out_data, exp_data);
  endtask

  // One cycle: check, drive, advance the model.
  task automatic step(input bit v, input bit r, input logic [IN_W-1:0] d);
    bit acc_w, acc_r;
    check_outputs();
    in_valid = v; out_req = r; in_data = d;
    acc_w = v && exp_ready(q.size());
    acc_r = r && exp_avail(q.size());
    last_wr_rej = v && !acc_w && !acc_r;
    last_rd_rej = r && !acc_r;
    last_both   = acc_w && acc_r;
    exp_valid   = acc_r;
    if (acc_r) begin
      for (int j = 0; j < OUT_B; j++) exp_data[j*BYTE_W +: BYTE_W] = q.pop_front();
      have_word = 1'b1;
      popped += OUT_B;
    end
    if (acc_w) begin
      // R2: byte i of the word follows byte i-1 in the stream
      for (int i = 0; i < IN_B; i++) q.push_back(d[i*BYTE_W +: BYTE_W]);
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    do_reset();

    // Directed: fill past full with pushes offered while in_ready is low (R6).
    for (int k = 0; k < DEPTH / IN_B + 3; k++) step(1'b1, 1'b0, 32'hA0B0C0D0 + k);
    // Directed: drain past empty with pops requested while out_avail is low (R7).
    for (int k = 0; k < DEPTH / OUT_B + 3; k++) step(1'b0, 1'b1, '0);
    // Directed: joint traffic across the wrap point (R8, R9).
    for (int k = 0; k < 24; k++) step(1'b1, 1'b1, 32'h11223344 ^ k);

    // Constrained random in phases of differing weights.
    for (int ph = 0; ph < 12; ph++) begin
      int pw, pr;
      case (ph % 4)
        0: begin pw = 85; pr = 20; end
        1: begin pw = 20; pr = 85; end
        2: begin pw = 50; pr = 50; end
        default: begin pw = 100; pr = 100; end
      endcase
      for (int k = 0; k < 200; k++)
        step(($urandom % 100) < pw, ($urandom % 100) < pr, $urandom);
      if (ph == 5) do_reset();
    end
    check_outputs();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule